// File: doc/BRIEF.md
# Calendar Alarm Comparator with Field Masks

This block watches a running calendar and raises an alarm when the time of day matches a programmed alarm word. The calendar arrives as BCD fields (seconds, minutes, hours with a PM bit, day-of-month and weekday) together with a 15-bit sub-second count. A 32-bit alarm word carries the target values. Each of its four calendar fields has its own don't-care bit. A separate sub-second target comes with a 4-bit code that sets how many low bits of the sub-second count take part in the compare.

When every field that is not masked agrees with the calendar, a sticky flag is set on the first cycle of agreement. The flag stays set until software pulses the clear strobe. An interrupt request follows the flag, gated by an interrupt enable. The alarm enable turns the whole compare off. The calendar counter, bus access and clock crossing sit outside this block.

Top module: `cal_alarm_cmp`

## Requirements
- R1: The alarm word holds the target seconds in bits [6:0], minutes in [14:8], hours in [21:16] and day in [29:24]. The don't-care bits are bit 7 (seconds), bit 15 (minutes), bit 23 (hours) and bit 31 (day). A field whose don't-care bit is 0 must equal its calendar field for a match. A field whose don't-care bit is 1 never prevents a match.
- R2: With all four don't-care bits set (word pattern 0x80808080) and sub-second code 0, the compare matches for any calendar value.
- R3: Bit 30 selects the day source. When it is 1, the day field is compared with the weekday. When it is 0, the day field is compared with the day-of-month.
- R4: When bit 30 is 1, only bits [26:24] of the alarm word are compared, against the weekday coded 1 to 7. Bits [29:27] have no effect in that case.
- R5: Sub-second code 0 ignores the sub-second count. Code n from 1 to 15 compares only bits [n-1:0] of the count with the sub-second target, so code 15 compares all 15 bits.
- R6: The PM bit (bit 22) must equal the calendar PM input only when 12-hour mode is on. In 24-hour mode the PM bit has no effect.
- R7: The flag rises on the clock edge that ends the first cycle in which the enabled compare matches.
- R8: The flag does not set again while the match persists. It stays set until the clear strobe is sampled. After a clear, a new match must first break before it can set the flag again.
- R9: While the alarm enable is low, the flag never sets. Raising the enable while the calendar already matches sets the flag on the next edge.
- R10: The interrupt request is high exactly when the flag is set and the interrupt enable is high.
- R11: When a new match rising and the clear strobe land in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| calSec | input | 7 | Calendar seconds, BCD |
| calMin | input | 7 | Calendar minutes, BCD |
| calHour | input | 6 | Calendar hours, BCD |
| calPm | input | 1 | Calendar PM indicator |
| calDate | input | 6 | Calendar day-of-month, BCD |
| calWeekday | input | 3 | Calendar weekday, 1 to 7 |
| hour12Mode | input | 1 | 12-hour mode active |
| subSec | input | 15 | Sub-second count |
| alarmReg | input | 32 | Alarm word (fields per R1, R3, R6) |
| subSecAlarm | input | 15 | Sub-second target |
| subSecCode | input | 4 | Sub-second compare width code (R5) |
| alarmEn | input | 1 | Alarm enable |
| irqEn | input | 1 | Interrupt enable |
| flagClr | input | 1 | Flag clear strobe |
| alarmFlag | output | 1 | Sticky alarm flag |
| alarmIrq | output | 1 | Interrupt request |

## Verification
Two events can fall in the same cycle: a fresh match rising and a software clear of the flag. The bench provokes this in three steps. It first lets the flag set, then breaks the match for one cycle, then restores the match in the same cycle that it pulses the clear strobe. The check passes only if the flag reads set after that edge. A separate step clears the flag while the match simply persists, and there the flag must stay clear.

// File: rtl/cal_alarm_pkg.sv
`timescale 1ns/1ps
package cal_alarm_pkg;

  // Alarm word as laid out on the input; the field order follows bit order.
  typedef struct packed {
    logic       dayMask;
    logic       weekSel;
    logic [5:0] day;
    logic       hourMask;
    logic       pm;
    logic [5:0] hour;
    logic       minMask;
    logic [6:0] min;
    logic       secMask;
    logic [6:0] sec;
  } alarmWord_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic compareEn;
    logic trackClr;
  } ctrlStrobe_t;

endpackage

// File: rtl/cal_alarm_dp.sv
`timescale 1ns/1ps
module cal_alarm_dp
  import cal_alarm_pkg::*;
#(
  parameter int SUBSEC_W = 15,
  parameter int CODE_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  alarmWord_t          alarmWord,
  input  logic [6:0]          calSec,
  input  logic [6:0]          calMin,
  input  logic [5:0]          calHour,
  input  logic                calPm,
  input  logic [5:0]          calDate,
  input  logic [2:0]          calWeekday,
  input  logic                hour12Mode,
  input  logic [SUBSEC_W-1:0] subSec,
  input  logic [SUBSEC_W-1:0] subSecAlarm,
  input  logic [CODE_W-1:0]   subSecCode,
  input  ctrlStrobe_t         strobe,
  output logic                matchNow,
  output logic                matchPrev
);

  logic secHit, minHit, hourHit, dayHit, subHit;
  logic [SUBSEC_W-1:0] bitCare;

  assign secHit  = alarmWord.secMask  || (alarmWord.sec == calSec);
  assign minHit  = alarmWord.minMask  || (alarmWord.min == calMin);
  assign hourHit = alarmWord.hourMask ||
                   ((alarmWord.hour == calHour) && (!hour12Mode || (alarmWord.pm == calPm)));
  assign dayHit  = alarmWord.dayMask  ||
                   (alarmWord.weekSel ? (alarmWord.day[2:0] == calWeekday)
                                      : (alarmWord.day == calDate));

  // Bit i of the sub-second count takes part when the code exceeds i.
  for (genvar i = 0; i < SUBSEC_W; i++) begin : g_care
    localparam logic [CODE_W-1:0] BIT_IDX = CODE_W'(i);
    assign bitCare[i] = (subSecCode > BIT_IDX);
  end

  assign subHit   = (((subSec ^ subSecAlarm) & bitCare) == '0);
  assign matchNow = strobe.compareEn && secHit && minHit && hourHit && dayHit && subHit;

  always_ff @(posedge clk) begin
    if (!rstN)               matchPrev <= 1'b0;
    else if (strobe.trackClr) matchPrev <= 1'b0;
    else                     matchPrev <= matchNow;
  end

  // R2
  all_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.compareEn && alarmWord.secMask && alarmWord.minMask &&
     alarmWord.hourMask && alarmWord.dayMask && (subSecCode == '0)) |-> matchNow);

  // R5
  full_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((subSecCode == '1) && (subSec != subSecAlarm)) |-> !matchNow);

endmodule

// File: rtl/cal_alarm_ctrl.sv
`timescale 1ns/1ps
module cal_alarm_ctrl
  import cal_alarm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        alarmEn,
  input  logic        irqEn,
  input  logic        flagClr,
  input  logic        matchNow,
  input  logic        matchPrev,
  output ctrlStrobe_t strobe,
  output logic        alarmFlag,
  output logic        alarmIrq
);

  logic hitRise;

  assign strobe.compareEn = alarmEn;
  assign strobe.trackClr  = !alarmEn;
  assign hitRise          = matchNow && !matchPrev;

  // A new hit wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN)        alarmFlag <= 1'b0;
    else if (hitRise) alarmFlag <= 1'b1;
    else if (flagClr) alarmFlag <= 1'b0;
  end

  assign alarmIrq = alarmFlag && irqEn;

  // R8
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(alarmFlag) |-> $past(flagClr));

  // R9
  disabled_no_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |-> $past(alarmEn));

  // R11
  set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchNow && !matchPrev && flagClr) |=> alarmFlag);

  // R7
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |-> $past(matchNow));

endmodule

// File: rtl/cal_alarm_cmp.sv
`timescale 1ns/1ps
module cal_alarm_cmp
  import cal_alarm_pkg::*;
#(
  parameter int SUBSEC_W = 15,
  parameter int CODE_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [6:0]          calSec,
  input  logic [6:0]          calMin,
  input  logic [5:0]          calHour,
  input  logic                calPm,
  input  logic [5:0]          calDate,
  input  logic [2:0]          calWeekday,
  input  logic                hour12Mode,
  input  logic [SUBSEC_W-1:0] subSec,
  input  logic [31:0]         alarmReg,
  input  logic [SUBSEC_W-1:0] subSecAlarm,
  input  logic [CODE_W-1:0]   subSecCode,
  input  logic                alarmEn,
  input  logic                irqEn,
  input  logic                flagClr,
  output logic                alarmFlag,
  output logic                alarmIrq
);

  alarmWord_t  alarmWord;
  ctrlStrobe_t strobe;
  logic        matchNow, matchPrev;

  assign alarmWord = alarmWord_t'(alarmReg);

  cal_alarm_dp #(.SUBSEC_W(SUBSEC_W), .CODE_W(CODE_W)) dp_i (
    .clk(clk), .rstN(rstN), .alarmWord(alarmWord),
    .calSec(calSec), .calMin(calMin), .calHour(calHour), .calPm(calPm),
    .calDate(calDate), .calWeekday(calWeekday), .hour12Mode(hour12Mode),
    .subSec(subSec), .subSecAlarm(subSecAlarm), .subSecCode(subSecCode),
    .strobe(strobe), .matchNow(matchNow), .matchPrev(matchPrev)
  );

  cal_alarm_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .alarmEn(alarmEn), .irqEn(irqEn), .flagClr(flagClr),
    .matchNow(matchNow), .matchPrev(matchPrev), .strobe(strobe),
    .alarmFlag(alarmFlag), .alarmIrq(alarmIrq)
  );

endmodule

// File: tb/cal_alarm_cmp_tb_top.sv
`timescale 1ns/1ps
module cal_alarm_cmp_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [6:0] calSec = 7'h45, calMin = 7'h30;
  logic [5:0] calHour = 6'h11, calDate = 6'h28;
  logic calPm = 1'b1, hour12Mode = 1'b0;
  logic [2:0] calWeekday = 3'd3;
  logic [14:0] subSec = '0, subSecAlarm = '0;
  logic [31:0] alarmReg = 32'h8080_8080;
  logic [3:0] subSecCode = '0;
  logic alarmEn = 1'b0, irqEn = 1'b0, flagClr = 1'b0;
  logic alarmFlag, alarmIrq;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_alarm_cmp dut_i (
    .clk(clk), .rstN(rstN), .calSec(calSec), .calMin(calMin), .calHour(calHour),
    .calPm(calPm), .calDate(calDate), .calWeekday(calWeekday), .hour12Mode(hour12Mode),
    .subSec(subSec), .alarmReg(alarmReg), .subSecAlarm(subSecAlarm),
    .subSecCode(subSecCode), .alarmEn(alarmEn), .irqEn(irqEn), .flagClr(flagClr),
    .alarmFlag(alarmFlag), .alarmIrq(alarmIrq)
  );

  function automatic logic [31:0] mkWord(input logic dm, input logic ws, input logic [5:0] d,
      input logic hm, input logic pm, input logic [5:0] h, input logic mm, input logic [6:0] m,
      input logic sm, input logic [6:0] s);
    return {dm, ws, d, hm, pm, h, mm, m, sm, s};
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Disable and clear, then enable with the current inputs; sample after one edge.
  task automatic runCase(input logic exp, input string tag);
    @(negedge clk); alarmEn = 1'b0; flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0; alarmEn = 1'b1;
    @(negedge clk); check(alarmFlag, exp, tag);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(alarmFlag, 1'b0, "reset flag");
    check(alarmIrq, 1'b0, "reset irq");
    rstN = 1'b1;

    // R2: everything masked matches any calendar
    for (int v = 0; v < 4; v++) begin
      calSec = 7'(v * 7); subSec = 15'(v * 1111);
      runCase(1'b1, "R2 all masked");
    end
    calSec = 7'h45; subSec = '0;

    // R1: each field mismatched, masked or not
    alarmReg = mkWord(0, 0, 6'h28, 0, 1, 6'h11, 0, 7'h30, 0, 7'h45);
    runCase(1'b1, "R1 all fields equal");
    for (int f = 0; f < 4; f++) begin
      for (int mk = 0; mk < 2; mk++) begin
        alarmReg = mkWord(f == 3 && mk == 1, 0, (f == 3) ? 6'h27 : 6'h28,
                          f == 2 && mk == 1, 1, (f == 2) ? 6'h12 : 6'h11,
                          f == 1 && mk == 1, (f == 1) ? 7'h31 : 7'h30,
                          f == 0 && mk == 1, (f == 0) ? 7'h46 : 7'h45);
        runCase(mk[0], $sformatf("R1 field %0d mask %0d", f, mk));
      end
    end

    // R3: weekday vs date selection
    for (int w = 1; w < 8; w++) begin
      calWeekday = 3'(w);
      alarmReg = mkWord(0, 1, 6'h03, 1, 0, 0, 1, 0, 1, 0);
      runCase(w == 3, $sformatf("R3 week mode weekday %0d", w));
    end
    calWeekday = 3'd5;
    alarmReg = mkWord(0, 0, 6'h28, 1, 0, 0, 1, 0, 1, 0);
    runCase(1'b1, "R3 date mode equal");
    alarmReg = mkWord(0, 0, 6'h05, 1, 0, 0, 1, 0, 1, 0);
    runCase(1'b0, "R3 date mode ignores weekday");

    // R4: upper day bits ignored in week mode
    alarmReg = mkWord(0, 1, 6'b111_101, 1, 0, 0, 1, 0, 1, 0);
    runCase(1'b1, "R4 upper bits ignored");
    alarmReg = mkWord(0, 1, 6'b111_100, 1, 0, 0, 1, 0, 1, 0);
    runCase(1'b0, "R4 low bits compared");

    // R6: PM bit only in 12-hour mode
    alarmReg = mkWord(1, 0, 0, 0, 0, 6'h11, 1, 0, 1, 0);
    hour12Mode = 1'b0; runCase(1'b1, "R6 24h ignores pm");
    hour12Mode = 1'b1; runCase(1'b0, "R6 12h pm mismatch");
    alarmReg = mkWord(1, 0, 0, 0, 1, 6'h11, 1, 0, 1, 0);
    runCase(1'b1, "R6 12h pm equal");
    hour12Mode = 1'b0;

    // R5: sub-second width sweep
    alarmReg = 32'h8080_8080;
    subSecAlarm = 15'h5A3C;
    for (int c = 0; c < 16; c++) begin
      subSecCode = 4'(c);
      subSec = subSecAlarm;
      runCase(1'b1, $sformatf("R5 code %0d equal", c));
      for (int k = 0; k < 15; k++) begin
        subSec = subSecAlarm ^ (15'd1 << k);
        runCase(!(k < c), $sformatf("R5 code %0d diff bit %0d", c, k));
      end
    end
    subSecCode = '0; subSec = '0;

    // R7, R8, R10, R11: flag timing and persistence
    alarmReg = mkWord(1, 0, 0, 1, 0, 0, 1, 0, 0, 7'h45);
    calSec = 7'h44;
    runCase(1'b0, "R7 no match");
    calSec = 7'h45;
    check(alarmFlag, 1'b0, "R7 not before edge");
    @(negedge clk); check(alarmFlag, 1'b1, "R7 set after one edge");
    check(alarmIrq, 1'b0, "R10 irq gated");
    irqEn = 1'b1; #1 check(alarmIrq, 1'b1, "R10 irq follows flag");
    flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
    check(alarmFlag, 1'b0, "R8 cleared");
    check(alarmIrq, 1'b0, "R10 irq after clear");
    repeat (3) @(negedge clk);
    check(alarmFlag, 1'b0, "R8 no reset while persisting");
    calSec = 7'h46;
    @(negedge clk); calSec = 7'h45;
    @(negedge clk); check(alarmFlag, 1'b1, "R8 sets on new match");
    repeat (2) @(negedge clk);
    check(alarmFlag, 1'b1, "R8 sticky");
    calSec = 7'h46;
    @(negedge clk); calSec = 7'h45; flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
    check(alarmFlag, 1'b1, "R11 set wins over clear");

    // R9: disabled blocks flag; enable with existing match sets it
    flagClr = 1'b1; alarmEn = 1'b0;
    @(negedge clk); flagClr = 1'b0;
    repeat (3) @(negedge clk);
    check(alarmFlag, 1'b0, "R9 disabled no flag");
    calSec = 7'h46;
    @(negedge clk); calSec = 7'h45;
    @(negedge clk); check(alarmFlag, 1'b0, "R9 disabled new match ignored");
    alarmEn = 1'b1;
    @(negedge clk); check(alarmFlag, 1'b1, "R9 enable with match sets");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule